// File: doc/BRIEF.md
# Serial debug memory-read command sequencer

This block is the target-side engine of a word-oriented debug link. The host exchanges one 16-bit word per transfer. In the same transfer, the block returns a 17-bit response: a status bit above 16 data bits. The bit-level shifter is outside the block. Each transfer arrives as a parallel word qualified by a one-cycle strobe, and the response for that transfer is the value on `rsp_word` in the cycle the strobe is taken.

A read takes three transfers: a command word, the upper half of the address and the lower half. After the third transfer the block holds a request on a memory port until the port acknowledges it, optionally with a bus error. Every response reports the outcome of the step before it, so the result comes back on later transfers. A long read returns its upper half on one transfer and its lower half on the next. The lower half travels with the transfer that carries the next command. After every accepted transfer the block ignores the strobe for a fixed recovery time.

Top module: `dbg_rd_seq`

## Requirements
- R1: After reset, `rsp_word` is 0x0FFFF (status 0, data 0xFFFF, meaning "command complete"), `xfer_busy` is 0 and `mem_req` is 0.
- R2: A transfer taken while the block waits for a command returns the outcome of the previous command. The command word is decoded as follows: bits [15:8] must be 0xA5 and bits [7:2] must be zero. Size bits [1:0] select 00 byte, 01 word or 10 long. Any other word is unimplemented.
- R3: The second transfer returns not-ready, 0x10000 (status 1, data 0). If the command was unimplemented, it returns illegal, 0x1FFFF, instead. After an illegal response the block waits for a command again, and the next response is not-ready.
- R4: The third transfer returns not-ready. The block then raises `mem_req` with `mem_addr` equal to {second word, third word} and `mem_size` equal to the size bits. It holds both until `mem_ack`.
- R5: While the access is outstanding, `rsp_word` is not-ready. A transfer taken then returns not-ready, and its word is ignored.
- R6: For a long read, the next transfer returns {0, `mem_rdata`[31:16]} and its word is ignored. The transfer after that returns {0, `mem_rdata`[15:0]}, and its word is decoded as the next command.
- R7: For a word read, the next transfer returns {0, `mem_rdata`[15:0]}. For a byte read, only bits [7:0] of that response are defined, and they equal `mem_rdata`[7:0]. In both cases that transfer's word is decoded as the next command.
- R8: If the access ends with `mem_err` high at `mem_ack`, the next transfer returns 0x10001 in place of data, and its word is decoded as the next command.
- R9: After an accepted transfer, `xfer_busy` is high for exactly GAP_CYC (default 32) cycles. A strobe during that window is ignored: it changes neither the response nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_vld | input | 1 | Host transfer strobe, one cycle |
| xfer_word | input | 16 | Host word of the transfer |
| xfer_busy | output | 1 | Recovery window after a transfer; strobes are ignored |
| rsp_word | output | 17 | Response returned on the next transfer {status, data} |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_size | output | 2 | Read size, 00 byte, 01 word, 10 long |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access ended in a bus error, valid with mem_ack |
| mem_rdata | input | 32 | Read data, right-aligned for byte and word reads |

## Verification
A sequencer state that is off by one step shows up within the next transfer. Not-ready, illegal and data responses have distinct codes, so a slipped step puts the wrong code in `rsp_word`. It also makes the wrong address half land in `mem_addr`, which the bench compares at the acknowledge.

A wrongly latched size or data half corrupts the very next result transfer. A recovery counter that is short or long changes the measured busy width, and a strobe injected inside the window would shift every later response.

// File: rtl/dbg_rd_seq.sv
module dbg_rd_seq #(
  parameter int GAP_CYC = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_vld,
  input  logic [15:0] xfer_word,
  output logic        xfer_busy,
  output logic [16:0] rsp_word,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [16:0] RSP_DONE = 17'h0FFFF;
  localparam logic [16:0] RSP_NRDY = 17'h10000;
  localparam logic [16:0] RSP_ILL  = 17'h1FFFF;
  localparam logic [16:0] RSP_BERR = 17'h10001;

  typedef enum logic [2:0] {ST_CMD, ST_AHI, ST_ALO, ST_MEM, ST_RHI} st_t;

  st_t         st;
  logic [GW-1:0] gap_q;
  logic [16:0] rsp_q;
  logic [31:0] addr_q;
  logic [15:0] low_q;
  logic [1:0]  size_q;
  logic        bad_q;

  wire take   = xfer_vld && !xfer_busy;
  wire cmd_ok = (xfer_word[15:8] == 8'hA5) && (xfer_word[7:2] == 6'd0) &&
                (xfer_word[1:0] != 2'b11);

  assign xfer_busy = (gap_q != '0);
  assign rsp_word  = rsp_q;
  assign mem_req   = (st == ST_MEM);
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_CMD;
      gap_q  <= '0;
      rsp_q  <= RSP_DONE;
      addr_q <= '0;
      low_q  <= '0;
      size_q <= 2'b00;
      bad_q  <= 1'b0;
    end else begin
      if (take)            gap_q <= GAP_CYC[GW-1:0];
      else if (gap_q != 0) gap_q <= gap_q - 1'b1;

      case (st)
        ST_CMD: if (take) begin
          size_q <= xfer_word[1:0];
          bad_q  <= !cmd_ok;
          rsp_q  <= cmd_ok ? RSP_NRDY : RSP_ILL;
          st     <= ST_AHI;
        end
        ST_AHI: if (take) begin
          rsp_q <= RSP_NRDY;
          if (bad_q) st <= ST_CMD;
          else begin
            addr_q[31:16] <= xfer_word;
            st            <= ST_ALO;
          end
        end
        ST_ALO: if (take) begin
          addr_q[15:0] <= xfer_word;
          rsp_q        <= RSP_NRDY;
          st           <= ST_MEM;
        end
        ST_MEM: if (mem_ack) begin
          if (mem_err) begin
            rsp_q <= RSP_BERR;
            st    <= ST_CMD;
          end else if (size_q == 2'b10) begin
            low_q <= mem_rdata[15:0];
            rsp_q <= {1'b0, mem_rdata[31:16]};
            st    <= ST_RHI;
          end else begin
            rsp_q <= (size_q == 2'b00) ? {9'd0, mem_rdata[7:0]} : {1'b0, mem_rdata[15:0]};
            st    <= ST_CMD;
          end
        end
        ST_RHI: if (take) begin
          rsp_q <= {1'b0, low_q};
          st    <= ST_CMD;
        end
        default: st <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/dbg_rd_seq_chk.sv
module dbg_rd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_vld,
  input logic        xfer_busy,
  input logic [16:0] rsp_word,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_err
);
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld && !xfer_busy |=> xfer_busy);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_vld && !xfer_busy) && !(mem_req && mem_ack) |=> $stable(rsp_word));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_nrdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> rsp_word == 17'h10000);

  assert_berr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> rsp_word == 17'h10001 && !mem_req);
endmodule

bind dbg_rd_seq dbg_rd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .xfer_busy(xfer_busy),
  .rsp_word(rsp_word), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_err(mem_err)
);

// File: tb/sim_dbg_rd_seq.sv
`timescale 1ns/1ps
module sim_dbg_rd_seq;
  logic        clk = 0, rst_n = 0, xfer_vld = 0;
  logic [15:0] xfer_word = 0;
  logic        xfer_busy, mem_req, mem_ack = 0, mem_err = 0;
  logic [16:0] rsp_word;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [1:0]  mem_size;

  int nvec = 0, nbad = 0;
  int lat_cfg = 0, lat_cnt = 0, ack_cnt = 0;
  bit err_cfg = 0;
  logic [31:0] got_addr;
  logic [1:0]  got_size;
  logic [16:0] exp_prev = 17'h0FFFF, exp_mask = 17'h1FFFF;
  string       exp_tag = "R2";

  localparam logic [16:0] NRDY = 17'h10000, ILL = 17'h1FFFF, BERR = 17'h10001;

  dbg_rd_seq u0 (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] mdata(logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] + 16'h0101};
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; mem_err = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_cfg) begin
        mem_ack = 1; mem_err = err_cfg; mem_rdata = mdata(mem_addr);
        got_addr = mem_addr; got_size = mem_size;
        lat_cnt = 0; ack_cnt++;
      end else lat_cnt++;
    end
  end

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp, logic [16:0] mask);
    nvec++;
    if ((act & mask) !== (exp & mask)) begin
      nbad++;
      $display("FAIL %s act=%05h exp=%05h", tag, act & mask, exp & mask);
    end
  endtask

  task automatic xfer(input logic [15:0] w, output logic [16:0] r);
    while (xfer_busy) @(negedge clk);
    r = rsp_word; xfer_vld = 1; xfer_word = w;
    @(negedge clk);
    xfer_vld = 0; xfer_word = $urandom;
  endtask

  task automatic run_read(logic [15:0] cmd, logic [31:0] addr, int lat, bit err, bit inject);
    logic [16:0] r, held;
    logic [31:0] d;
    int n0;
    bit legal = cmd[15:8] == 8'hA5 && cmd[7:2] == 0 && cmd[1:0] != 2'b11;
    lat_cfg = lat; err_cfg = err;
    xfer(cmd, r);
    check(exp_tag, r, exp_prev, exp_mask);
    if (inject) begin
      int bw = 1;
      repeat (4) @(negedge clk);
      held = rsp_word; xfer_vld = 1; xfer_word = 16'hDEAD;
      @(negedge clk); xfer_vld = 0;
      check("R9 ignored strobe", rsp_word, held, 17'h1FFFF);
      while (xfer_busy) begin @(negedge clk); bw++; end
      check("R9 busy width", 17'(bw + 4), 17'd32, 17'h1FFFF);
    end
    xfer(addr[31:16], r);
    exp_mask = 17'h1FFFF;
    if (!legal) begin
      check("R3 illegal", r, ILL, exp_mask);
      exp_prev = NRDY; exp_tag = "R3 after illegal";
      return;
    end
    check("R3 not ready", r, NRDY, exp_mask);
    n0 = ack_cnt;
    xfer(addr[15:0], r);
    check("R4 third", r, NRDY, exp_mask);
    if (lat > 40) begin
      xfer(16'h1234, r);
      check("R5 outstanding", r, NRDY, exp_mask);
    end
    while (ack_cnt == n0) @(negedge clk);
    @(negedge clk);
    check("R4 addr hi", {1'b0, got_addr[31:16]}, {1'b0, addr[31:16]}, exp_mask);
    check("R4 addr lo", {1'b0, got_addr[15:0]}, {1'b0, addr[15:0]}, exp_mask);
    check("R4 size", {15'd0, got_size}, {15'd0, cmd[1:0]}, exp_mask);
    d = mdata(addr);
    if (err) begin
      exp_prev = BERR; exp_tag = "R8 bus error";
    end else if (cmd[1:0] == 2'b10) begin
      xfer(16'hBEEF, r);
      check("R6 long high", r, {1'b0, d[31:16]}, exp_mask);
      exp_prev = {1'b0, d[15:0]}; exp_tag = "R6 long low";
    end else if (cmd[1:0] == 2'b01) begin
      exp_prev = {1'b0, d[15:0]}; exp_tag = "R7 word";
    end else begin
      exp_prev = {9'd0, d[7:0]}; exp_mask = 17'h100FF; exp_tag = "R7 byte";
    end
  endtask

  initial begin
    logic [15:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp", rsp_word, 17'h0FFFF, 17'h1FFFF);
    check("R1 idle", {15'd0, xfer_busy, mem_req}, 17'd0, 17'h1FFFF);
    run_read(16'hA502, 32'h1234_5678, 2, 0, 1);
    run_read(16'hA501, 32'hCAFE_0F0F, 60, 0, 0);
    run_read(16'hA500, 32'h0000_00FF, 0, 0, 0);
    run_read(16'hA503, 32'h0, 0, 0, 0);
    run_read(16'h7702, 32'h0, 0, 0, 0);
    run_read(16'hA502, 32'hFFFF_0000, 1, 1, 0);
    run_read(16'hA501, 32'h8000_0001, 90, 1, 0);
    run_read(16'hA502, 32'hFFFF_FFFF, 3, 0, 0);
    for (int i = 0; i < 70; i++) begin
      c = {8'hA5, 6'd0, 2'($urandom_range(0, 2))};
      if ($urandom_range(0, 9) == 0) c = 16'($urandom);
      run_read(c, $urandom, $urandom_range(0, 4), $urandom_range(0, 7) == 0,
               $urandom_range(0, 7) == 0);
    end
    run_read(16'hA500, 32'h0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule